// File: doc/BRIEF.md
# Core Test Wrapper Serial Controller

This block puts a serial test wrapper around an embedded core. An integrator drives a wrapper clock, an active-low wrapper reset and four strobes: instruction select, shift, capture and update. The wrapper holds a 4-bit instruction register, a single-bit bypass cell and an 8-bit user data register that stands in for access to a core instrument. One of these segments is connected between the serial input and the serial output at any time.

The instruction select strobe alone decides whether the instruction register is in the path. When that strobe is low, the data segment in the path is chosen by the active instruction, which is the update stage of the instruction register. Shifting goes least significant bit first. The serial output is re-timed on the falling edge of the wrapper clock, so wrappers can be chained without hold races. The update stage of the user data register appears on a parallel output.

Top module: `core_wrap_ctrl`

## Requirements
- R1: While the wrapper reset is low, the user data output is 0, the serial output is 0 and the active instruction selects the bypass cell. The reset acts at once, without waiting for a clock edge.
- R2: With the instruction select strobe high, a capture cycle (capture high, shift low) loads the instruction shift stage with binary 0101. A following scan returns the bits 1,0,1,0 on the serial output.
- R3: The active instruction changes only on a clock edge where update is high, shift is low and the instruction select strobe is high. Shifting a new code without an update leaves the data path unchanged.
- R4: Active code 0001 puts the 8-bit user data register in the path. A capture followed by 8 shifts returns its current update value, least significant bit first. A following update cycle loads the shifted-in byte onto the user data output.
- R5: Active code 0000 puts a one-bit bypass cell in the path. It captures 0 and delays the serial data by exactly one clock.
- R6: Every active code other than 0001, 0010 to 1111 included, selects the bypass cell.
- R7: The user data output holds its value during shifting. It also holds on update cycles while the instruction select strobe is high or while another data segment is selected.
- R8: The serial output changes only on the falling edge of the wrapper clock. It is the bit that sits at the least significant end of the selected segment.
- R9: Pulling the reset low in the middle of a scan returns the wrapper to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Wrapper clock |
| wrst_n | input | 1 | Asynchronous active-low wrapper reset |
| sel_ir | input | 1 | High: instruction register in path; low: decoded data segment |
| shift_en | input | 1 | Shift the selected segment one bit toward the output |
| capture_en | input | 1 | Parallel load of the selected segment (with shift low) |
| update_en | input | 1 | Transfer the shift stage to the update stage (with shift low) |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, re-timed on the falling clock edge |
| udr_q | output | 8 | Update stage of the user data register |

## Verification
The hardest case to reach is an instruction that has been shifted in but never updated. Only the data path shows that the decoded selection did not move. The bench shifts code 0001 with no update and then runs a data scan; a bypass cell shows up as a one-bit delay with a leading 0, while the user data register would show up as an 8-bit readback. Each of the sixteen instruction codes is then loaded and probed the same way. A separate step pulls the reset low in the middle of a user data scan. The falling-edge re-timing is checked by sampling the serial output on both sides of each rising edge.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
   typedef enum logic [0:0] {
      DSEG_BYP = 1'b0,
      DSEG_USR = 1'b1
   } dseg_e;
endpackage

// File: rtl/wrap_seg.sv
module wrap_seg #(
   parameter int          W       = 4,
   parameter bit          HAS_UPD = 1'b1,
   parameter logic [W-1:0] RST_UPD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         cap,
   input  logic         shf,
   input  logic         upd,
   input  logic         si,
   input  logic [W-1:0] cap_val,
   output logic [W-1:0] sr_q,
   output logic [W-1:0] upd_q
);
   initial begin
      if (W < 1) $error("wrap_seg: W must be at least 1");
   end

   logic [W:0] cat;
   always_comb cat = {si, sr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (sel) begin
         if (shf)      sr_q <= cat[W:1];
         else if (cap) sr_q <= cap_val;
      end
   end

   generate
      if (HAS_UPD) begin : g_upd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 upd_q <= RST_UPD;
            else if (sel && upd && !shf) upd_q <= sr_q;
         end
         // R3
         upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd || !sel) |=> $stable(upd_q));
         // R7
         upd_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            shf |=> $stable(upd_q));
      end else begin : g_noupd
         assign upd_q = '0;
      end
   endgenerate

   // R8
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shf) |=> sr_q[W-1] == $past(si));
endmodule

// File: rtl/wrap_decode.sv
module wrap_decode
   import wrap_pkg::*;
#(
   parameter int              IR_W     = 4,
   parameter logic [IR_W-1:0] CODE_USR = 1
) (
   input  logic [IR_W-1:0] ir_act,
   output dseg_e           dseg
);
   always_comb begin
      if (ir_act == CODE_USR) dseg = DSEG_USR;
      else                    dseg = DSEG_BYP;
   end
endmodule

// File: rtl/core_wrap_ctrl.sv
module core_wrap_ctrl
   import wrap_pkg::*;
#(
   parameter int               IR_W        = 4,
   parameter int               UDR_W       = 8,
   parameter logic [IR_W-1:0]  CODE_BYP    = 4'b0000,
   parameter logic [IR_W-1:0]  CODE_USR    = 4'b0001,
   parameter logic [IR_W-1:0]  IR_CAPT     = 4'b0101,
   parameter bit               OUT_ON_FALL = 1'b1
) (
   input  logic             wrck,
   input  logic             wrst_n,
   input  logic             sel_ir,
   input  logic             shift_en,
   input  logic             capture_en,
   input  logic             update_en,
   input  logic             ser_in,
   output logic             ser_out,
   output logic [UDR_W-1:0] udr_q
);
   localparam int BYP_W = 1;

   initial begin
      if (IR_W < 2)              $error("core_wrap_ctrl: IR_W must be at least 2");
      if (IR_CAPT[1:0] != 2'b01) $error("core_wrap_ctrl: IR capture must end in 01");
      if (CODE_BYP == CODE_USR)  $error("core_wrap_ctrl: codes must differ");
      if (UDR_W < 1)             $error("core_wrap_ctrl: UDR_W must be at least 1");
   end

   logic [IR_W-1:0]  ir_sr, ir_act;
   logic [BYP_W-1:0] byp_sr, byp_unused;
   logic [UDR_W-1:0] usr_sr;
   dseg_e            dseg;
   logic             byp_sel, usr_sel, so_pre;

   wrap_seg #(.W(IR_W), .HAS_UPD(1'b1), .RST_UPD(CODE_BYP)) ir_i (
      .clk(wrck), .rst_n(wrst_n), .sel(sel_ir), .cap(capture_en),
      .shf(shift_en), .upd(update_en), .si(ser_in), .cap_val(IR_CAPT),
      .sr_q(ir_sr), .upd_q(ir_act));

   wrap_decode #(.IR_W(IR_W), .CODE_USR(CODE_USR)) dec_i (
      .ir_act(ir_act), .dseg(dseg));

   assign byp_sel = !sel_ir && (dseg == DSEG_BYP);
   assign usr_sel = !sel_ir && (dseg == DSEG_USR);

   wrap_seg #(.W(BYP_W), .HAS_UPD(1'b0), .RST_UPD(1'b0)) byp_i (
      .clk(wrck), .rst_n(wrst_n), .sel(byp_sel), .cap(capture_en),
      .shf(shift_en), .upd(update_en), .si(ser_in), .cap_val(1'b0),
      .sr_q(byp_sr), .upd_q(byp_unused));

   wrap_seg #(.W(UDR_W), .HAS_UPD(1'b1), .RST_UPD('0)) usr_i (
      .clk(wrck), .rst_n(wrst_n), .sel(usr_sel), .cap(capture_en),
      .shf(shift_en), .upd(update_en), .si(ser_in), .cap_val(udr_q),
      .sr_q(usr_sr), .upd_q(udr_q));

   always_comb begin
      if (sel_ir)                so_pre = ir_sr[0];
      else if (dseg == DSEG_USR) so_pre = usr_sr[0];
      else                       so_pre = byp_sr[0];
   end

   generate
      if (OUT_ON_FALL) begin : g_fall
         always_ff @(negedge wrck or negedge wrst_n) begin
            if (!wrst_n) ser_out <= 1'b0;
            else         ser_out <= so_pre;
         end
      end else begin : g_rise
         always_ff @(posedge wrck or negedge wrst_n) begin
            if (!wrst_n) ser_out <= 1'b0;
            else         ser_out <= so_pre;
         end
      end
   endgenerate

   // R2
   ir_capt_chk: assert property (@(posedge wrck) disable iff (!wrst_n)
      (sel_ir && capture_en && !shift_en) |=> ir_sr == IR_CAPT);
   // R3
   dseg_hold_chk: assert property (@(posedge wrck) disable iff (!wrst_n)
      (!update_en || shift_en || !sel_ir) |=> $stable(dseg));
   // R5
   byp_capt_chk: assert property (@(posedge wrck) disable iff (!wrst_n)
      (byp_sel && capture_en && !shift_en) |=> byp_sr == '0);
   // R7
   udr_other_chk: assert property (@(posedge wrck) disable iff (!wrst_n)
      !usr_sel |=> $stable(udr_q));
   // R1
   rst_state_chk: assert property (@(posedge wrck) !wrst_n |-> (udr_q == '0 && dseg == DSEG_BYP));
endmodule

// File: tb/core_wrap_ctrl_tb.sv
module core_wrap_ctrl_tb_top;
   localparam int CLK_PER = 10;

   logic wrck = 1'b0, wrst_n = 1'b0, sel_ir = 1'b0, shift_en = 1'b0;
   logic capture_en = 1'b0, update_en = 1'b0, ser_in = 1'b0;
   logic ser_out;
   logic [7:0] udr_q;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) wrck = ~wrck;

   core_wrap_ctrl dut_i (
      .wrck(wrck), .wrst_n(wrst_n), .sel_ir(sel_ir), .shift_en(shift_en),
      .capture_en(capture_en), .update_en(update_en), .ser_in(ser_in),
      .ser_out(ser_out), .udr_q(udr_q));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge wrck);
      @(negedge wrck);
      #2;
   endtask

   // loads an instruction, checks the captured IR pattern (R2)
   task automatic load_ir(input logic [3:0] code, input bit do_upd);
      logic [3:0] got;
      sel_ir = 1'b1; capture_en = 1'b1; cyc(); capture_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         got[i] = ser_out; ser_in = code[i]; shift_en = 1'b1; cyc();
      end
      shift_en = 1'b0;
      check("R2 ir capture", {28'd0, got}, 32'h5);
      if (do_upd) begin update_en = 1'b1; cyc(); update_en = 1'b0; end
      sel_ir = 1'b0;
   endtask

   // data scan expecting the one-bit bypass cell (R5, R8)
   task automatic byp_scan(input logic [7:0] pat, input string req);
      logic [8:0] got;
      logic a;
      capture_en = 1'b1; cyc(); capture_en = 1'b0;
      for (int i = 0; i < 9; i++) begin
         got[i] = ser_out; a = ser_out;
         ser_in = (i < 8) ? pat[i] : 1'b0; shift_en = 1'b1;
         @(posedge wrck); #1;
         check("R8 out stable across rising edge", {31'd0, ser_out}, {31'd0, a});
         @(negedge wrck); #2;
      end
      shift_en = 1'b0;
      check(req, {23'd0, got}, {23'd0, pat, 1'b0});
   endtask

   // user data scan: returns the captured bits, then updates
   task automatic usr_scan(input logic [7:0] v, input logic [7:0] old_v);
      logic [7:0] got;
      capture_en = 1'b1; cyc(); capture_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         got[i] = ser_out; ser_in = v[i]; shift_en = 1'b1; cyc();
      end
      shift_en = 1'b0;
      check("R4 readback", {24'd0, got}, {24'd0, old_v});
      check("R7 hold during shift", {24'd0, udr_q}, {24'd0, old_v});
      update_en = 1'b1; cyc(); update_en = 1'b0;
      check("R4 update loads byte", {24'd0, udr_q}, {24'd0, v});
   endtask

   initial begin
      #(CLK_PER * 100000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] prev;
      repeat (2) cyc();
      check("R1 udr reset", {24'd0, udr_q}, 32'd0);
      check("R1 ser_out reset", {31'd0, ser_out}, 32'd0);
      wrst_n = 1'b1; cyc();
      byp_scan(8'h3C, "R1 bypass after reset");
      // R3: shift 0001 without update; path must stay bypass
      load_ir(4'b0001, 1'b0);
      byp_scan(8'hA6, "R3 no update keeps bypass");
      // R4 / R7
      load_ir(4'b0001, 1'b1);
      prev = 8'h00;
      for (int k = 0; k < 12; k++) begin
         logic [7:0] v;
         v = 8'((k * 37 + 5) ^ (k << 4));
         usr_scan(v, prev);
         prev = v;
      end
      // R7: update while IR in path leaves udr alone
      sel_ir = 1'b1; update_en = 1'b1; cyc(); update_en = 1'b0; sel_ir = 1'b0;
      check("R7 update with IR selected", {24'd0, udr_q}, {24'd0, prev});
      // R5 / R6 sweep
      for (int c = 0; c < 16; c++) begin
         load_ir(4'(c), 1'b1);
         if (c == 1) usr_scan(8'(c * 17 + 3), prev);
         else begin
            byp_scan(8'(c * 29 + 1), c == 0 ? "R5 bypass code" : "R6 undefined code bypass");
            check("R7 udr untouched in bypass", {24'd0, udr_q}, {24'd0, prev});
         end
         if (c == 1) prev = 8'(c * 17 + 3);
      end
      // R9: reset in the middle of a user data scan
      load_ir(4'b0001, 1'b1);
      usr_scan(8'h5A, prev);
      capture_en = 1'b1; cyc(); capture_en = 1'b0;
      ser_in = 1'b1; shift_en = 1'b1; cyc(); cyc();
      wrst_n = 1'b0; #1;
      check("R9 udr cleared at once", {24'd0, udr_q}, 32'd0);
      check("R9 ser_out cleared", {31'd0, ser_out}, 32'd0);
      shift_en = 1'b0; cyc();
      wrst_n = 1'b1; cyc();
      byp_scan(8'hC3, "R9 bypass after mid-scan reset");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule